// File: doc/BRIEF.md
# Double-Buffered PCM Sample Port

This block sits between a host bus and a voice converter core that produces and consumes one 16-bit linear PCM sample every 125 µs. It has two directions. For host-to-core traffic, the host writes a holding register and the core reads a separate working register. For core-to-host traffic, the core's result is copied into a host-visible register. Every copy between the two sides happens on a single core sample strobe. Because of this, the host always has one full sample period to supply or collect a word.

Each sample strobe also sets a sticky event flag. The flag can be routed to an interrupt output, and the strobe can raise two DMA requests, one for each direction. Each DMA request is cleared by the host access that services it. The interrupt and the DMA requests share one trigger, so enabling the interrupt together with either DMA direction is flagged as an illegal configuration.

A freeze input supports debug halts. While freeze is high, the output register keeps its value and a status read does not clear the event flag.

Top module: `pcm_sample_port`

## Requirements
- R1: After reset, `host_rdata` (the output register), `core_word`, `event_flag`, `irq`, both DMA requests and `config_error` are all zero.
- R2: A host write of `host_wdata` (with `host_wr_in` high) does not change `core_word`. On the next `sample_strobe`, `core_word` takes the value of the last word written before that strobe.
- R3: On a `sample_strobe` with `freeze` low, `host_rdata` takes `core_result`. Without a strobe, `host_rdata` holds its value whatever `core_result` does.
- R4: On a `sample_strobe` with `freeze` high, `host_rdata` keeps its previous value.
- R5: Every `sample_strobe` sets `event_flag`. The flag stays set until it is cleared as described in R6.
- R6: A status read (`host_rd_status` high) with `freeze` low clears `event_flag` in the following cycle. With `freeze` high, a status read leaves the flag set. A strobe in the same cycle as a status read wins, and the flag stays set.
- R7: `irq` is high exactly when `event_flag` is set and `irq_en` is high.
- R8: The two DMA requests behave as follows:
  - A strobe with `dma_in_en` high raises `dma_in_req`, and a host input write clears it.
  - A strobe with `dma_out_en` high raises `dma_out_req`, and a host output read (`host_rd_out`) clears it.
  - Each access clears only its own request.
- R9: `config_error` is high whenever `irq_en` is high together with `dma_in_en` or `dma_out_en`, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| freeze | input | 1 | Debug halt: blocks output update and clear-on-read |
| sample_strobe | input | 1 | One-cycle core sample tick (every 125 µs) |
| core_result | input | 16 | Sample produced by the converter core |
| core_word | output | 16 | Core-side working copy of the host input sample |
| host_wr_in | input | 1 | Host write of the input sample register |
| host_wdata | input | 16 | Host write data |
| host_rd_out | input | 1 | Host read of the output sample register |
| host_rd_status | input | 1 | Host read of the status (clear-on-read event flag) |
| host_rdata | output | 16 | Host-visible output sample register |
| irq_en | input | 1 | Interrupt enable |
| dma_in_en | input | 1 | Input-direction DMA enable |
| dma_out_en | input | 1 | Output-direction DMA enable |
| event_flag | output | 1 | Sticky sample event flag |
| irq | output | 1 | Interrupt request |
| dma_in_req | output | 1 | DMA request for a new input sample |
| dma_out_req | output | 1 | DMA request to collect the output sample |
| config_error | output | 1 | Illegal enable combination |

## Verification
The input path is driven with two successive words. This separates the core copy tracking the holding register from the core copy updating only at the strobe. The output path is checked with `core_result` changing both with and without a strobe, and again under freeze, which separates normal capture from a blocked update. The event flag and the DMA requests are driven by strobes, status reads, host reads and host writes in several orders. This shows that each access clears only what it owns and that freeze blocks clearing. Three enable combinations separate legal from illegal configurations.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    parameter int PCM_W = 16;

    typedef logic [PCM_W-1:0] pcm_word_t;

    typedef struct packed {
        pcm_word_t hold;
        pcm_word_t work;
    } in_state_t;

    typedef struct packed {
        pcm_word_t shown;
    } out_state_t;

    typedef struct packed {
        logic flag;
        logic in_req;
        logic out_req;
    } evt_state_t;
endpackage

// File: rtl/pcm_in_buffer.sv
module pcm_in_buffer
    import pcm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample_strobe,
    input  logic      host_wr,
    input  pcm_word_t host_wdata,
    output pcm_word_t core_word
);
    in_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_wr) begin
            st_d.hold = host_wdata;
        end
        // The core side takes the word held before this edge
        if (sample_strobe) begin
            st_d.work = st_q.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_word = st_q.work;

    AST_WORK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |=> $stable(core_word)); // R2
    AST_WORK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> core_word == $past(st_q.hold)); // R2
endmodule

// File: rtl/pcm_out_buffer.sv
module pcm_out_buffer
    import pcm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample_strobe,
    input  logic      freeze,
    input  pcm_word_t core_result,
    output pcm_word_t host_rdata
);
    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_strobe && !freeze) begin
            st_d.shown = core_result;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.shown;

    AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && !freeze) |=> host_rdata == $past(core_result)); // R3
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |=> $stable(host_rdata)); // R3
    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && freeze) |=> $stable(host_rdata)); // R4
endmodule

// File: rtl/pcm_event_ctrl.sv
module pcm_event_ctrl
    import pcm_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_strobe,
    input  logic freeze,
    input  logic host_rd_status,
    input  logic host_wr_in,
    input  logic host_rd_out,
    input  logic irq_en,
    input  logic dma_in_en,
    input  logic dma_out_en,
    output logic event_flag,
    output logic irq,
    output logic dma_in_req,
    output logic dma_out_req,
    output logic config_error
);
    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clears first, so a strobe in the same cycle wins
        if (host_rd_status && !freeze) begin
            st_d.flag = 1'b0;
        end
        if (host_wr_in) begin
            st_d.in_req = 1'b0;
        end
        if (host_rd_out) begin
            st_d.out_req = 1'b0;
        end
        if (sample_strobe) begin
            st_d.flag = 1'b1;
            if (dma_in_en) begin
                st_d.in_req = 1'b1;
            end
            if (dma_out_en) begin
                st_d.out_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_flag   = st_q.flag;
    assign irq          = st_q.flag && irq_en;
    assign dma_in_req   = st_q.in_req && dma_in_en;
    assign dma_out_req  = st_q.out_req && dma_out_en;
    assign config_error = irq_en && (dma_in_en || dma_out_en);

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> event_flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (event_flag && !host_rd_status) |=> event_flag); // R5
    AST_FLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (event_flag && freeze) |=> event_flag); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_status && !freeze && !sample_strobe) |=> !event_flag); // R6
    AST_IN_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_in && !sample_strobe) |=> !dma_in_req); // R8
    AST_OUT_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_out && !sample_strobe) |=> !dma_out_req); // R8
endmodule

// File: rtl/pcm_sample_port.sv
module pcm_sample_port
    import pcm_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             sample_strobe,
    input  logic [PCM_W-1:0] core_result,
    output logic [PCM_W-1:0] core_word,
    input  logic             host_wr_in,
    input  logic [PCM_W-1:0] host_wdata,
    input  logic             host_rd_out,
    input  logic             host_rd_status,
    output logic [PCM_W-1:0] host_rdata,
    input  logic             irq_en,
    input  logic             dma_in_en,
    input  logic             dma_out_en,
    output logic             event_flag,
    output logic             irq,
    output logic             dma_in_req,
    output logic             dma_out_req,
    output logic             config_error
);
    pcm_in_buffer u_in (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_strobe (sample_strobe),
        .host_wr       (host_wr_in),
        .host_wdata    (host_wdata),
        .core_word     (core_word)
    );

    pcm_out_buffer u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_strobe (sample_strobe),
        .freeze        (freeze),
        .core_result   (core_result),
        .host_rdata    (host_rdata)
    );

    pcm_event_ctrl u_evt (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_strobe  (sample_strobe),
        .freeze         (freeze),
        .host_rd_status (host_rd_status),
        .host_wr_in     (host_wr_in),
        .host_rd_out    (host_rd_out),
        .irq_en         (irq_en),
        .dma_in_en      (dma_in_en),
        .dma_out_en     (dma_out_en),
        .event_flag     (event_flag),
        .irq            (irq),
        .dma_in_req     (dma_in_req),
        .dma_out_req    (dma_out_req),
        .config_error   (config_error)
    );

    AST_CFG_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && (dma_in_en || dma_out_en)) |-> config_error); // R9
endmodule

// File: tb/pcm_sample_port_bench.sv
module pcm_sample_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic        sample_strobe = 1'b0;
    logic [15:0] core_result = '0;
    logic [15:0] core_word;
    logic        host_wr_in = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        host_rd_out = 1'b0;
    logic        host_rd_status = 1'b0;
    logic [15:0] host_rdata;
    logic        irq_en = 1'b0;
    logic        dma_in_en = 1'b0;
    logic        dma_out_en = 1'b0;
    logic        event_flag, irq, dma_in_req, dma_out_req, config_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_sample_port u_pcm_sample_port (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .sample_strobe(sample_strobe),
        .core_result(core_result), .core_word(core_word),
        .host_wr_in(host_wr_in), .host_wdata(host_wdata),
        .host_rd_out(host_rd_out), .host_rd_status(host_rd_status),
        .host_rdata(host_rdata), .irq_en(irq_en), .dma_in_en(dma_in_en),
        .dma_out_en(dma_out_en), .event_flag(event_flag), .irq(irq),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .config_error(config_error)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic strobe();
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
    endtask

    task automatic host_write(input logic [15:0] w);
        host_wr_in = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr_in = 1'b0;
    endtask

    task automatic status_read();
        host_rd_status = 1'b1;
        @(negedge clk);
        host_rd_status = 1'b0;
    endtask

    task automatic test_reset();
        check("R1", "pcm out", host_rdata, 16'h0);
        check("R1", "core word", core_word, 16'h0);
        check("R1", "flag", {15'b0, event_flag}, 16'h0);
        check("R1", "irq", {15'b0, irq}, 16'h0);
        check("R1", "reqs", {14'b0, dma_in_req, dma_out_req}, 16'h0);
        check("R1", "cfg", {15'b0, config_error}, 16'h0);
    endtask

    task automatic test_in_path();
        host_write(16'h1234);
        check("R2", "core word before strobe", core_word, 16'h0);
        strobe();
        check("R2", "core word after strobe", core_word, 16'h1234);
        host_write(16'hBEEF);
        check("R2", "core word held", core_word, 16'h1234);
        strobe();
        check("R2", "core word second", core_word, 16'hBEEF);
    endtask

    task automatic test_out_path();
        core_result = 16'hA5A5;
        @(negedge clk);
        check("R3", "no strobe no capture", host_rdata, 16'h0);
        strobe();
        check("R3", "capture", host_rdata, 16'hA5A5);
        core_result = 16'h0F0F;
        @(negedge clk);
        @(negedge clk);
        check("R3", "hold without strobe", host_rdata, 16'hA5A5);
    endtask

    task automatic test_freeze();
        status_read();
        check("R6", "flag cleared", {15'b0, event_flag}, 16'h0);
        freeze = 1'b1;
        core_result = 16'h7777;
        strobe();
        check("R4", "frozen output", host_rdata, 16'hA5A5);
        check("R5", "flag set under freeze", {15'b0, event_flag}, 16'h1);
        status_read();
        check("R6", "no clear under freeze", {15'b0, event_flag}, 16'h1);
        freeze = 1'b0;
        status_read();
        check("R6", "clear after freeze", {15'b0, event_flag}, 16'h0);
        strobe();
        check("R3", "capture after freeze", host_rdata, 16'h7777);
    endtask

    task automatic test_event();
        status_read();
        strobe();
        repeat (3) @(negedge clk);
        check("R5", "flag sticky", {15'b0, event_flag}, 16'h1);
        check("R7", "irq off when disabled", {15'b0, irq}, 16'h0);
        irq_en = 1'b1;
        #1;
        check("R7", "irq on", {15'b0, irq}, 16'h1);
        host_rd_status = 1'b1;
        sample_strobe = 1'b1;
        @(negedge clk);
        host_rd_status = 1'b0;
        sample_strobe = 1'b0;
        check("R6", "strobe beats read", {15'b0, event_flag}, 16'h1);
        status_read();
        check("R6", "flag clear", {15'b0, event_flag}, 16'h0);
        check("R7", "irq drops", {15'b0, irq}, 16'h0);
        irq_en = 1'b0;
    endtask

    task automatic test_dma();
        dma_in_en = 1'b1;
        dma_out_en = 1'b1;
        strobe();
        check("R8", "both reqs", {14'b0, dma_in_req, dma_out_req}, 16'h3);
        check("R9", "legal cfg", {15'b0, config_error}, 16'h0);
        host_rd_out = 1'b1;
        @(negedge clk);
        host_rd_out = 1'b0;
        check("R8", "out read clears out only", {14'b0, dma_in_req, dma_out_req}, 16'h2);
        host_write(16'h0001);
        check("R8", "in write clears in", {14'b0, dma_in_req, dma_out_req}, 16'h0);
        dma_in_en = 1'b0;
        strobe();
        check("R8", "out only", {14'b0, dma_in_req, dma_out_req}, 16'h1);
        dma_out_en = 1'b0;
    endtask

    task automatic test_cfg();
        irq_en = 1'b1; dma_in_en = 1'b1; dma_out_en = 1'b0;
        #1 check("R9", "irq+in", {15'b0, config_error}, 16'h1);
        dma_in_en = 1'b0; dma_out_en = 1'b1;
        #1 check("R9", "irq+out", {15'b0, config_error}, 16'h1);
        dma_out_en = 1'b0;
        #1 check("R9", "irq only", {15'b0, config_error}, 16'h0);
        irq_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_in_path();
        test_out_path();
        test_freeze();
        test_event();
        test_dma();
        test_cfg();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1-watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule